// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the sampling tick of a serial receiver and transmitter from a fast reference clock. The rate is set in two stages. An integer pre-divider, chosen by a 3-bit coded field, slows the reference clock down to an enable pulse. A fractional modulator then sets the rate exactly. On every enabled cycle it adds an increment to an accumulator, and each time the accumulator passes a modulus it issues one 16x sampling tick. The ticks are spread as evenly as the ratio allows.

The 16x tick is divided once more by the oversampling factor to give one pulse per bit period. A separate counter, clocked by the same divided enable, issues a strobe once per millisecond. Software writes three 16-bit values: the increment, the modulus and the millisecond reload. The resulting bit rate is (divided clock / 16) x (INC + 1) / (MOD + 1). Writing the modulus restarts every counter, so a new rate begins from a known phase.

Top module: `frac_baud_gen`

## Requirements
- R1: Reset clears INC, MOD and the millisecond reload to zero and drives all three outputs low. Until the first write, the block then issues one 16x tick on every divided-clock cycle and no millisecond strobe.
- R2: The divide ratio d of the pre-divider comes from the field value f as d = 6 - f for f from 0 to 5. Both f = 6 and f = 7 give d = 7. The divided enable fires once every d reference cycles, so f = 5 means no division.
- R3: Over a window that starts at a MOD write, let E be the number of divided-clock cycles. The number of 16x ticks is floor(E x (INC+1) / (MOD+1)).
- R4: When INC >= MOD, the 16x tick fires on every divided-clock cycle and never more often. Two ticks are never closer than d reference cycles.
- R5: When INC < MOD, the spacing between consecutive 16x ticks is either floor((MOD+1)/(INC+1)) or ceil((MOD+1)/(INC+1)) divided-clock periods.
- R6: The bit-rate tick is high on every sixteenth 16x tick, counted from the last clear, in the same cycle as that 16x tick. It is never high without a 16x tick.
- R7: With a nonzero reload R, the millisecond strobe is one cycle long and fires once every R divided-clock cycles. A reload of zero stops the strobe.
- R8: A MOD write clears the accumulator, the pre-divider, the sixteenth-tick counter and the millisecond counter in the same clock edge. The first 16x tick then comes d x ceil((MOD+1)/(INC+1)) reference cycles after the write edge, and no output is high in the cycle just after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_inc | input | 1 | Loads wr_data into the increment register |
| wr_mod | input | 1 | Loads wr_data into the modulus register and restarts all counters |
| wr_ms | input | 1 | Loads wr_data into the millisecond reload and restarts the millisecond counter |
| wr_data | input | 16 | Write data for the three registers |
| div_sel | input | 3 | Coded pre-divider field (d = 6 - f, 6 and 7 give 7) |
| tick16 | output | 1 | 16x oversampling tick, one cycle wide |
| bit_tick | output | 1 | One pulse per bit period, on every sixteenth 16x tick |
| ms_tick | output | 1 | Millisecond strobe, one cycle wide |

## Verification
The bench builds the block with its default 16-bit register width and an oversampling factor of 16. This lets it write the extreme modulus 65535 and increments above the modulus, so both the finest fractional ratio and the saturated rate can be reached. Every coded divider value from 0 to 7 is exercised. This includes the two codes that share divide-by-7 and the code that bypasses division. Tick counts, tick spacing, first-tick delay and strobe counts are compared with exact rational values that the bench works out for windows of a few thousand cycles.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int SEL_W   = 3;
    localparam int RATIO_W = 3;

    // Coded field to divide ratio: 6 - f for f <= 5, else 7.
    function automatic logic [RATIO_W-1:0] sel_to_ratio(input logic [SEL_W-1:0] sel);
        if (sel >= 3'd6)
            return 3'd7;
        else
            return 3'd6 - sel;
    endfunction
endpackage

// File: rtl/fbg_prediv.sv
module fbg_prediv
    import fbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             en_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
    } pd_state_t;

    pd_state_t st_d, st_q;
    logic [RATIO_W-1:0] ratio;

    always_comb begin
        ratio = sel_to_ratio(sel_i);
        en_o  = (st_q.cnt >= (ratio - RATIO_W'(1)));
        st_d  = st_q;
        if (clr_i || en_o)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + RATIO_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R2: with a ratio above one, two enables never come back to back
    p_en_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && !clr_i && (sel_i < 3'd5 || sel_i > 3'd5)) |=> (!en_o || !$stable(sel_i)));
endmodule

// File: rtl/fbg_modulator.sv
module fbg_modulator #(
    parameter int REG_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [REG_W-1:0] inc_i,
    input  logic [REG_W-1:0] mod_i,
    output logic             tick16_o,
    output logic             bit_tick_o
);
    localparam int SUB_W = $clog2(OVS);
    localparam int SUM_W = REG_W + 2;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        logic [REG_W-1:0] acc;
        logic [SUB_W-1:0] sub;
        logic             tick16;
        logic             bit_tick;
    } mod_state_t;

    mod_state_t st_d, st_q;
    logic [SUM_W-1:0] sum, span;
    logic             saturate, hit;

    always_comb begin
        span     = SUM_W'(mod_i) + SUM_W'(1);
        sum      = SUM_W'(st_q.acc) + SUM_W'(inc_i) + SUM_W'(1);
        saturate = (inc_i >= mod_i);
        hit      = 1'b0;
        st_d          = st_q;
        st_d.tick16   = 1'b0;
        st_d.bit_tick = 1'b0;
        if (clr_i) begin
            st_d = '0;
        end else if (en_i) begin
            if (saturate) begin
                st_d.acc = '0;
                hit      = 1'b1;
            end else if (sum >= span) begin
                st_d.acc = REG_W'(sum - span);
                hit      = 1'b1;
            end else begin
                st_d.acc = REG_W'(sum);
            end
            if (hit) begin
                st_d.tick16   = 1'b1;
                st_d.sub      = st_q.sub + SUB_W'(1);
                st_d.bit_tick = (st_q.sub == SUB_LAST);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tick16_o   = st_q.tick16;
    assign bit_tick_o = st_q.bit_tick;

    // R4: a 16x tick only follows a divided-clock enable
    p_tick_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick16_o |-> $past(en_i));
    // R3: the remainder stays below the modulus span
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc <= mod_i);
    // R6: the bit tick rides on a 16x tick
    p_bit_with_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> tick16_o);
endmodule

// File: rtl/fbg_ms_timer.sv
module fbg_ms_timer #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [REG_W-1:0] reload_i,
    output logic             stb_o
);
    typedef struct packed {
        logic [REG_W-1:0] cnt;
        logic             stb;
    } ms_state_t;

    ms_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (clr_i) begin
            st_d = '0;
        end else if (en_i && (reload_i != '0)) begin
            if (st_q.cnt >= (reload_i - REG_W'(1))) begin
                st_d.cnt = '0;
                st_d.stb = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + REG_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign stb_o = st_q.stb;

    // R7: strobe only after an enable with a live reload
    p_ms_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> ($past(en_i) && $past(reload_i != '0)));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_inc,
    input  logic             wr_mod,
    input  logic             wr_ms,
    input  logic [REG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick16,
    output logic             bit_tick,
    output logic             ms_tick
);
    typedef struct packed {
        logic [REG_W-1:0] inc;
        logic [REG_W-1:0] modv;
        logic [REG_W-1:0] ms;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic div_en;
    logic clr_ms;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_inc) cfg_d.inc  = wr_data;
        if (wr_mod) cfg_d.modv = wr_data;
        if (wr_ms)  cfg_d.ms   = wr_data;
        clr_ms = wr_mod || wr_ms;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else
            cfg_q <= cfg_d;
    end

    fbg_prediv u_prediv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (wr_mod),
        .sel_i (div_sel),
        .en_o  (div_en)
    );

    fbg_modulator #(.REG_W(REG_W), .OVS(OVS)) u_mod (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (wr_mod),
        .en_i       (div_en),
        .inc_i      (cfg_q.inc),
        .mod_i      (cfg_q.modv),
        .tick16_o   (tick16),
        .bit_tick_o (bit_tick)
    );

    fbg_ms_timer #(.REG_W(REG_W)) u_ms (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_ms),
        .en_i     (div_en),
        .reload_i (cfg_q.ms),
        .stb_o    (ms_tick)
    );

    // R8: the cycle after a modulus write is quiet on every output
    p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_mod) |-> (!tick16 && !bit_tick && !ms_tick));
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_inc = 1'b0, wr_mod = 1'b0, wr_ms = 1'b0;
    logic [15:0] wr_data = '0;
    logic [2:0]  div_sel = 3'd5;
    logic        tick16, bit_tick, ms_tick;

    int n_chk = 0;
    int n_bad = 0;
    longint t_cnt, b_cnt, m_cnt, orphan, gmin, gmax, first_j;

    always #2 clk = ~clk;

    frac_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_inc(wr_inc), .wr_mod(wr_mod), .wr_ms(wr_ms),
        .wr_data(wr_data), .div_sel(div_sel),
        .tick16(tick16), .bit_tick(bit_tick), .ms_tick(ms_tick)
    );

    task automatic check(input string req, input longint act, input longint exp, input longint tol);
        longint diff;
        n_chk++;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint ratio_of(input int f);
        return (f >= 6) ? 7 : 6 - f;
    endfunction

    function automatic longint exp_ticks(input longint e, input longint i, input longint m);
        if (i >= m) return e;
        return (e * (i + 1)) / (m + 1);
    endfunction

    task automatic wr(input int which, input logic [15:0] val);
        @(negedge clk);
        wr_data = val;
        wr_inc = (which == 0);
        wr_mod = (which == 1);
        wr_ms  = (which == 2);
        @(negedge clk);
        wr_inc = 1'b0; wr_mod = 1'b0; wr_ms = 1'b0;
    endtask

    task automatic observe(input int n);
        longint last_j;
        t_cnt = 0; b_cnt = 0; m_cnt = 0; orphan = 0;
        gmin = 64'h7fffffff; gmax = 0; first_j = -1; last_j = -1;
        for (int j = 0; j < n; j++) begin
            if (tick16) begin
                t_cnt++;
                if (first_j < 0) first_j = j;
                if (last_j >= 0) begin
                    if (j - last_j < gmin) gmin = j - last_j;
                    if (j - last_j > gmax) gmax = j - last_j;
                end
                last_j = j;
            end
            if (bit_tick) b_cnt++;
            if (bit_tick && !tick16) orphan++;
            if (ms_tick) m_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic run_cfg(input int f, input longint i, input longint m, input longint ms,
                           input int n, input bit chk_gap);
        longint d, e, et, lo, hi;
        div_sel = 3'(f);
        wr(2, 16'(ms));
        wr(0, 16'(i));
        wr(1, 16'(m));
        observe(n);
        d  = ratio_of(f);
        e  = (n - 1) / d;
        et = exp_ticks(e, i, m);
        check("R3 tick count", t_cnt, et, 1);
        check("R6 bit tick count", b_cnt, et / 16, 1);
        check("R6 bit tick without 16x tick", orphan, 0, 0);
        check("R7 ms strobe count", m_cnt, (ms == 0) ? 0 : e / ms, 1);
        if (i >= m) begin
            lo = d; hi = d;
        end else begin
            lo = d * ((m + 1) / (i + 1));
            hi = d * ((m + 1 + i) / (i + 1));
        end
        check("R8 first tick delay", first_j, hi, 0);
        if (chk_gap && t_cnt >= 2) begin
            check("R5 min tick gap", gmin, lo, 0);
            check("R5 max tick gap", gmax, hi, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check("R1 tick16 in reset", tick16, 0, 0);
        check("R1 bit_tick in reset", bit_tick, 0, 0);
        check("R1 ms_tick in reset", ms_tick, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        observe(32);
        check("R1 tick every cycle after reset", t_cnt, 32, 0);
        check("R1 bit ticks after reset", b_cnt, 2, 0);
        check("R1 no ms strobe after reset", m_cnt, 0, 0);

        // R8 exact first tick and R3 base rate, no pre-division
        run_cfg(5, 0, 3, 10, 2000, 1);
        // R5 evenness with d = 2 and ratio 3/10
        run_cfg(4, 2, 9, 7, 3000, 1);
        // R2 code 0 gives divide-by-6, finest modulus
        run_cfg(0, 9999, 65535, 3, 6000, 1);
        // R2 codes 6 and 7 share divide-by-7
        run_cfg(6, 1, 4, 5, 3000, 1);
        run_cfg(7, 1, 4, 5, 3000, 1);
        run_cfg(1, 1, 4, 2, 3000, 1);
        run_cfg(2, 1, 4, 2, 3000, 1);
        // R4 saturation: INC above MOD at d = 3
        run_cfg(3, 500, 10, 1, 2000, 1);
        // R4 INC equal to MOD at d = 1
        run_cfg(5, 77, 77, 0, 500, 1);
        // R7 reload zero stops the strobe
        run_cfg(5, 3, 20, 0, 1500, 1);

        for (int k = 0; k < 10; k++) begin
            int f;
            longint m, i, ms;
            f  = $urandom_range(0, 7);
            m  = $urandom_range(0, 4000);
            i  = $urandom_range(0, 4500);
            ms = $urandom_range(0, 400);
            run_cfg(f, i, m, ms, 4000, 1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule